// File: doc/BRIEF.md
# Steerable Microprocessor Watchdog Timer

This block watches a host processor. Software loads an 8-bit control byte, and the watchdog then counts slow base ticks, with a nominal rate of 16 per second. If neither a transition on the watchdog input pin nor a new control write arrives before the programmed span runs out, the watchdog times out. The span is a 5-bit multiplier times one of four resolutions. On a timeout the block sets a sticky flag, and a steering bit sends the event to one of two places. One is a level interrupt, which stays high until software writes the control byte. The other is a low-going reset pulse of fixed length. That pulse also clears the control byte and emits a one-cycle strobe so that neighbouring blocks can clear their own mode bits.

The controller is a four-state machine:
- `WD_OFF` (disarmed) moves to `WD_ARMED` on a write with a nonzero multiplier.
- `WD_ARMED` (counting) restarts in place on a write or on a pin edge, and returns to `WD_OFF` on a write with a zero multiplier.
- On expiry, `WD_ARMED` moves to `WD_ALERT` when the steering bit is 0, and to `WD_PULSE` when it is 1.
- `WD_ALERT` (interrupt held) leaves only on a write. It goes to `WD_ARMED` if the new multiplier is nonzero and to `WD_OFF` otherwise.
- `WD_PULSE` (reset pulse active) returns to `WD_OFF` once the pulse length has elapsed.

Top module: `wdog_steer`

## Requirements
- R1: After reset all outputs are inactive: `irq_o`=0, `rst_pulse_no`=1, `wdf_o`=0, `clr_ctl_o`=0, `cfg_o`=0x00. With no write, no timeout ever happens.
- R2: The control byte holds a multiplier M in bits 6..2 and a resolution code in bits 1..0. Codes 00, 01, 10 and 11 give 1, 4, 16 and 64 base ticks. A timeout occurs on exactly the M×res-th tick after the last restart and not before. Example: 0x0E gives 48 ticks, and 0x7F gives 1984 ticks.
- R3: With bit 7 = 0, a timeout drives `irq_o` high. It stays high until a control write.
- R4: With bit 7 = 1, a timeout drives `rst_pulse_no` low for exactly PULSE_TICKS base ticks (default 4), after which it returns high. `irq_o` stays low.
- R5: `wdf_o` goes high on every timeout. It stays high until a one-cycle `flag_rd_i` strobe clears it.
- R6: Both a rising and a falling transition on `wdi_i` restart the countdown while it is counting.
- R7: Any control write while counting restarts the countdown, even one that rewrites the same value.
- R8: Writing 0x00 while the interrupt is held releases `irq_o` and leaves the watchdog disarmed.
- R9: A control byte whose multiplier field is zero leaves the watchdog disarmed, whatever its other bits hold.
- R10: A pulse-steered timeout clears the control byte to 0x00. It raises `clr_ctl_o` for exactly one clock cycle, and the watchdog stays disarmed afterwards.
- R11: Control writes made while the reset pulse is active are ignored. Pin transitions made while the interrupt is held do not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| tick_i | input | 1 | One-cycle base tick strobe (1/16 s nominal) |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte: steer[7], multiplier[6:2], resolution[1:0] |
| flag_rd_i | input | 1 | Flag register read strobe; clears the flag |
| wdi_i | input | 1 | Asynchronous watchdog kick pin; either edge restarts |
| irq_o | output | 1 | Interrupt, active high, held until a control write |
| rst_pulse_no | output | 1 | Reset pulse, active low |
| wdf_o | output | 1 | Sticky watchdog timeout flag |
| cfg_o | output | 8 | Current control byte |
| clr_ctl_o | output | 1 | One-cycle strobe asking neighbours to clear their mode bits |

## Verification
The embedded properties assume that `wr_en_i` and `flag_rd_i` are synchronous, that `tick_i` is a strobe no wider than one clock, and that ticks are spaced well apart compared with the three-cycle latency of the pin synchroniser. The stimulus changes every input on the falling clock edge. It produces a tick once every four clocks and holds each strobe for one cycle. It moves `wdi_i` or writes the register only just after a tick, so that a restart never lands in the same cycle as an expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_ALERT = 2'd2,
        WD_PULSE = 2'd3
    } wd_state_e;

    localparam int unsigned RES_W = 2;

endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic edge_o
);

    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], pin_i};
        end
    end

    assign edge_o = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];

    p_edge_from_history_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> (chain_q[SYNC_STAGES] != $past(chain_q[SYNC_STAGES])));

endmodule

// File: rtl/wdog_span.sv
module wdog_span #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   next_cnt;

    assign next_cnt  = (CNT_W+1)'(cnt_q) + (CNT_W+1)'(1);
    assign expired_o = en_i && tick_i && (next_cnt >= {1'b0, target_i});

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && tick_i) begin
            cnt_q <= next_cnt[CNT_W-1:0];
        end
    end

    p_cnt_below_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (target_i != '0)) |-> (cnt_q < target_i));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned MULT_W      = 5,
    parameter int unsigned RES_SHIFT   = 2,
    parameter int unsigned PULSE_TICKS = 4,
    parameter int unsigned CNT_W       = 11,
    parameter int unsigned REG_W       = MULT_W + RES_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             flag_rd_i,
    input  logic             wdi_edge_i,
    input  logic             expired_i,
    output logic             cnt_clr_o,
    output logic             cnt_en_o,
    output logic [CNT_W-1:0] target_o,
    output logic [REG_W-1:0] cfg_o,
    output logic             irq_o,
    output logic             rst_n_o,
    output logic             wdf_o,
    output logic             clr_ctl_o
);

    localparam int unsigned STEER_BIT = REG_W - 1;

    wd_state_e        state_q, state_d;
    logic [REG_W-1:0] cfg_q;
    logic             wdf_q;
    logic             clr_q;

    logic              wr_ok;
    logic              wr_mult_nz;
    logic              restart;
    logic              timeout;
    logic              enter_pulse;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;

    assign mult       = cfg_q[REG_W-2:RES_W];
    assign res        = cfg_q[RES_W-1:0];
    assign wr_ok      = wr_en_i && (state_q != WD_PULSE);
    assign wr_mult_nz = |wr_data_i[REG_W-2:RES_W];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (wr_ok && wr_mult_nz) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (wr_ok) begin
                    state_d = wr_mult_nz ? WD_ARMED : WD_OFF;
                end else if (!wdi_edge_i && expired_i) begin
                    state_d = cfg_q[STEER_BIT] ? WD_PULSE : WD_ALERT;
                end
            end
            WD_ALERT: begin
                if (wr_ok) state_d = wr_mult_nz ? WD_ARMED : WD_OFF;
            end
            WD_PULSE: begin
                if (expired_i) state_d = WD_OFF;
            end
            default: state_d = WD_OFF;
        endcase
    end

    assign restart     = (state_q == WD_ARMED) && (wr_ok || wdi_edge_i);
    assign timeout     = (state_q == WD_ARMED) && ((state_d == WD_ALERT) || (state_d == WD_PULSE));
    assign enter_pulse = (state_q == WD_ARMED) && (state_d == WD_PULSE);
    assign cnt_clr_o   = restart || (state_d != state_q);
    assign cnt_en_o    = (state_q == WD_ARMED) || (state_q == WD_PULSE);

    always_comb begin
        if (state_q == WD_PULSE) begin
            target_o = CNT_W'(PULSE_TICKS);
        end else begin
            target_o = CNT_W'(mult) << (RES_SHIFT * res);
        end
    end

    // state register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WD_OFF;
            cfg_q   <= '0;
            wdf_q   <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_ok) begin
                cfg_q <= wr_data_i;
            end else if (enter_pulse) begin
                cfg_q <= '0;
            end
            if (timeout) begin
                wdf_q <= 1'b1;
            end else if (flag_rd_i) begin
                wdf_q <= 1'b0;
            end
            clr_q <= enter_pulse;
        end
    end

    // output process
    always_comb begin
        irq_o     = (state_q == WD_ALERT);
        rst_n_o   = (state_q != WD_PULSE);
        wdf_o     = wdf_q;
        cfg_o     = cfg_q;
        clr_ctl_o = clr_q;
    end

    p_outputs_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> rst_n_o);

    p_irq_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !wr_en_i) |=> irq_o);

    p_armed_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WD_ARMED) |-> (mult != '0));

    p_pulse_clears_cfg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_n_o) |-> ((cfg_q == '0) && wdf_q));

    p_clr_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_q |=> !clr_q);

    p_wdf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdf_q && !flag_rd_i) |=> wdf_q);

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdog_pkg::*;
#(
    parameter int unsigned MULT_W      = 5,
    parameter int unsigned RES_SHIFT   = 2,
    parameter int unsigned PULSE_TICKS = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  wr_en_i,
    input  logic [MULT_W+RES_W:0] wr_data_i,
    input  logic                  flag_rd_i,
    input  logic                  wdi_i,
    output logic                  irq_o,
    output logic                  rst_pulse_no,
    output logic                  wdf_o,
    output logic [MULT_W+RES_W:0] cfg_o,
    output logic                  clr_ctl_o
);

    localparam int unsigned REG_W = MULT_W + RES_W + 1;
    localparam int unsigned CNT_W = MULT_W + RES_SHIFT * ((1 << RES_W) - 1);

    logic             wdi_edge;
    logic             expired;
    logic             cnt_clr;
    logic             cnt_en;
    logic [CNT_W-1:0] target;

    wdog_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (wdi_i),
        .edge_o (wdi_edge)
    );

    wdog_span #(
        .CNT_W(CNT_W)
    ) u_span (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .clr_i     (cnt_clr),
        .en_i      (cnt_en),
        .target_i  (target),
        .expired_o (expired)
    );

    wdog_ctrl #(
        .MULT_W     (MULT_W),
        .RES_SHIFT  (RES_SHIFT),
        .PULSE_TICKS(PULSE_TICKS),
        .CNT_W      (CNT_W),
        .REG_W      (REG_W)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .flag_rd_i  (flag_rd_i),
        .wdi_edge_i (wdi_edge),
        .expired_i  (expired),
        .cnt_clr_o  (cnt_clr),
        .cnt_en_o   (cnt_en),
        .target_o   (target),
        .cfg_o      (cfg_o),
        .irq_o      (irq_o),
        .rst_n_o    (rst_pulse_no),
        .wdf_o      (wdf_o),
        .clr_ctl_o  (clr_ctl_o)
    );

endmodule

// File: tb/test_wdog_steer.sv
module test_wdog_steer;

    localparam int PULSE = 4;

    typedef struct {
        string      tag;
        logic       irq;
        logic       rstn;
        logic       wdf;
        logic [7:0] cfg;
        logic       clr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_rd = 1'b0;
    logic       wdi = 1'b0;
    logic       irq, rstn_p, wdf, clr;
    logic [7:0] cfg;

    int   checks = 0;
    int   errors = 0;
    int   tick_seen = 0;
    int   base = 0;
    int   tdiv = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    wdog_steer #(.PULSE_TICKS(PULSE)) i_wdog_steer (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .flag_rd_i    (flag_rd),
        .wdi_i        (wdi),
        .irq_o        (irq),
        .rst_pulse_no (rstn_p),
        .wdf_o        (wdf),
        .cfg_o        (cfg),
        .clr_ctl_o    (clr)
    );

    // tick strobe: one cycle in four
    always @(negedge clk) begin
        tdiv <= (tdiv + 1) % 4;
        tick <= (tdiv == 3);
    end

    always @(posedge clk) if (tick) tick_seen <= tick_seen + 1;

    // monitor: pops expectations and compares with the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (irq !== e.irq || rstn_p !== e.rstn || wdf !== e.wdf ||
                    cfg !== e.cfg || clr !== e.clr) begin
                    errors++;
                    $display("FAIL %s: actual irq=%b rstn=%b wdf=%b cfg=%h clr=%b expected irq=%b rstn=%b wdf=%b cfg=%h clr=%b",
                             e.tag, irq, rstn_p, wdf, cfg, clr, e.irq, e.rstn, e.wdf, e.cfg, e.clr);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic i, input logic r, input logic w,
                       input logic [7:0] c, input logic cl);
        exp_t e;
        e.tag = tag; e.irq = i; e.rstn = r; e.wdf = w; e.cfg = c; e.clr = cl;
        exp_q.push_back(e);
    endtask

    task automatic wr_raw(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_raw(d);
        base = tick_seen;
    endtask

    task automatic rd_flag();
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    task automatic wdi_toggle();
        wdi = ~wdi;
        repeat (3) @(negedge clk);
        base = tick_seen;
    endtask

    task automatic wait_ticks(input int n);
        while ((tick_seen - base) < n) @(negedge clk);
    endtask

    task automatic timeout_case(input logic [7:0] d, input int n, input string tag);
        wr(d);
        wait_ticks(n - 1);
        chk({tag, " one tick early"}, 0, 1, 0, d, 0);
        wait_ticks(n);
        chk({tag, " on final tick"}, 1, 1, 1, d, 0);
        rd_flag();
        wr(8'h00);
        chk({tag, " cleaned up"}, 0, 1, 0, 8'h00, 0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all R): actual still running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", 0, 1, 0, 8'h00, 0);
        base = tick_seen;
        wait_ticks(100);
        chk("R1 idle never times out", 0, 1, 0, 8'h00, 0);

        wr(8'h0C);
        wait_ticks(2);
        chk("R2 m3 res00 tick2", 0, 1, 0, 8'h0C, 0);
        wait_ticks(3);
        chk("R3 irq at tick3", 1, 1, 1, 8'h0C, 0);
        wait_ticks(13);
        chk("R3 irq held", 1, 1, 1, 8'h0C, 0);
        wdi_toggle();
        repeat (5) @(negedge clk);
        chk("R11 wdi ignored while irq held", 1, 1, 1, 8'h0C, 0);
        rd_flag();
        chk("R5 flag read clears wdf", 1, 1, 0, 8'h0C, 0);
        wr(8'h00);
        chk("R8 zero write releases irq", 0, 1, 0, 8'h00, 0);
        wait_ticks(200);
        chk("R8 stays disarmed", 0, 1, 0, 8'h00, 0);

        timeout_case(8'h09, 8, "R2 res01 m2");
        timeout_case(8'h0E, 48, "R2 res10 m3");
        timeout_case(8'h07, 64, "R2 res11 m1");
        timeout_case(8'h7F, 1984, "R2 max span");

        // R6: both pin edges restart (wdi is 1 here, so falling first)
        wr(8'h10);
        wait_ticks(3);
        wdi_toggle();
        wait_ticks(3);
        chk("R6 falling edge restarted", 0, 1, 0, 8'h10, 0);
        wdi_toggle();
        wait_ticks(3);
        chk("R6 rising edge restarted", 0, 1, 0, 8'h10, 0);
        wait_ticks(4);
        chk("R6 timeout after restart", 1, 1, 1, 8'h10, 0);
        rd_flag();
        wr(8'h00);

        // R7: rewrite restarts
        wr(8'h10);
        wait_ticks(3);
        wr(8'h10);
        wait_ticks(3);
        chk("R7 rewrite restarted", 0, 1, 0, 8'h10, 0);
        wait_ticks(4);
        chk("R7 timeout after rewrite", 1, 1, 1, 8'h10, 0);
        rd_flag();
        wr(8'h00);

        // R9: zero multiplier
        wr(8'h83);
        wait_ticks(300);
        chk("R9 zero multiplier disarmed", 0, 1, 0, 8'h83, 0);
        wr(8'h00);

        // R4 / R10 / R11: pulse steering
        wr(8'h88);
        wait_ticks(1);
        chk("R4 before timeout", 0, 1, 0, 8'h88, 0);
        wait_ticks(2);
        chk("R4 pulse starts", 0, 0, 1, 8'h00, 1);
        base = tick_seen;
        @(negedge clk);
        chk("R10 clear strobe one cycle", 0, 0, 1, 8'h00, 0);
        wr_raw(8'h55);
        chk("R11 write ignored during pulse", 0, 0, 1, 8'h00, 0);
        wait_ticks(PULSE - 1);
        chk("R4 pulse still low", 0, 0, 1, 8'h00, 0);
        wait_ticks(PULSE);
        chk("R4 pulse ends", 0, 1, 1, 8'h00, 0);
        wait_ticks(PULSE + 100);
        chk("R10 disarmed after pulse", 0, 1, 1, 8'h00, 0);
        rd_flag();
        chk("R5 flag cleared after pulse", 0, 1, 0, 8'h00, 0);

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule